// File: doc/BRIEF.md
# Prescaled Core Timebase Generator

This block drives a 64-bit free-running system counter. Each clock it looks at one of two qualifying pulse inputs, a reference-crystal pulse or an alternate bus-clock pulse. Both pulses are already in the block's clock domain. A control bit chooses which of the two pulses counts as an input cycle.

On every selected input cycle, the programmed prescaler value is added to a fractional accumulator. When the sum reaches 2^31, the block produces a counter tick and keeps only the remainder. The tick rate is therefore the input rate times the prescaler value divided by 2^31. A prescaler value of 0x80000000 gives one tick per input cycle. On each tick the counter advances by 1 or by 2, as a second control bit selects. The tick and the step size are also presented as outputs, so a neighbouring compare unit can follow the counter.

Configuration uses a plain write strobe with a one-bit register select. A written value takes effect on the clock after the write.

Top module: `ctb_timebase`

## Requirements
- R1: After reset the counter is 0, `tick_o` is 0, `inc_o` is 0, the control bits are 0 and the prescaler is 0. With a prescaler of 0, no tick ever occurs, whatever pulses arrive.
- R2: Control bit 8 (register select 0) chooses the input. A value of 0 counts `xtal_pulse_i` and a value of 1 counts `alt_pulse_i`. Pulses on the input that is not selected have no effect on the accumulator, the ticks or the counter.
- R3: Control bit 9 chooses the step size. A value of 0 adds 1 per tick and a value of 1 adds 2 per tick. `inc_o` shows the step (1 or 2) in a tick cycle and shows 0 in every other cycle. Writing 0 to the control register selects the crystal input with a step of 1.
- R4: With a prescaler of 0x80000000 (register select 1), every selected input cycle yields exactly one tick.
- R5: On each selected input cycle, the accumulator (reset 0, less than 2^31) is increased by the prescaler value. A tick occurs when the sum is at least 2^31, and the accumulator then keeps the sum modulo 2^31.
- R6: A prescaler write above 0x80000000 is stored as 0x80000000, so there is at most one tick per input cycle.
- R7: A selected input pulse in cycle N that produces a tick raises `tick_o` in cycle N+1. In that same cycle `count_o` already includes the step. In any cycle without a tick, the counter holds its value.
- R8: A register write in cycle N takes effect on input pulses from cycle N+1 onward. Clock cycles with no selected pulse leave the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_pulse_i | input | 1 | Crystal reference input cycle, one clock wide |
| alt_pulse_i | input | 1 | Alternate bus-clock input cycle, one clock wide |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 1 | Register select: 0 control, 1 prescaler |
| cfg_wdata_i | input | 32 | Write data |
| tick_o | output | 1 | Counter tick this cycle |
| inc_o | output | 2 | Step applied this cycle (0, 1 or 2) |
| count_o | output | 64 | System counter value |

## Verification
The bench runs several prescaler values against the same pulse patterns. 0x80000000 shows a direct one-to-one mapping. 0x40000000 and 0x20000000 show an exact divide by 2 and by 4. 0x55555555 forces carries with an uneven remainder, which shows whether the remainder is kept or dropped on each tick. Values above the limit check the clamp.

Pulse patterns are continuous, sparse pseudo-random, and pulses on the input that is not selected. These separate the source-select path from the accumulator. Changing the step and source in the middle of a run, while the accumulator holds a remainder, shows that configuration changes do not reset the fraction.

// File: rtl/ctb_pkg.sv
package ctb_pkg;
  localparam int CFG_W       = 32;
  localparam int SRC_BIT     = 8;
  localparam int STEP_BIT    = 9;
  localparam bit SEL_CTRL    = 1'b0;
  localparam bit SEL_PRESC   = 1'b1;
  typedef enum logic {SRC_XTAL = 1'b0, SRC_ALT = 1'b1} src_e;
  typedef enum logic [1:0] {INC_NONE = 2'd0, INC_ONE = 2'd1, INC_TWO = 2'd2} inc_e;
endpackage

// File: rtl/ctb_cfg_regs.sv
module ctb_cfg_regs
  import ctb_pkg::*;
#(
  parameter int FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              sel,
  input  logic [CFG_W-1:0]  wdata,
  output src_e              src,
  output logic              step_two,
  output logic [FRAC_W-1:0] presc
);
  localparam logic [FRAC_W-1:0] UNITY = FRAC_W'(1) << (FRAC_W - 1);

  logic [FRAC_W-1:0] wr_presc;
  assign wr_presc = FRAC_W'(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src      <= SRC_XTAL;
      step_two <= 1'b0;
      presc    <= '0;
    end else if (wr) begin
      if (sel == SEL_CTRL) begin
        src      <= src_e'(wdata[SRC_BIT]);
        step_two <= wdata[STEP_BIT];
      end else begin
        presc <= (wr_presc > UNITY) ? UNITY : wr_presc;
      end
    end
  end
endmodule

// File: rtl/ctb_frac_accum.sv
module ctb_frac_accum
  import ctb_pkg::*;
#(
  parameter int FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xtal_pulse,
  input  logic              alt_pulse,
  input  src_e              src,
  input  logic [FRAC_W-1:0] presc,
  output logic              fire
);
  localparam int REM_W = FRAC_W - 1;

  logic             in_cycle;
  logic [REM_W-1:0] rem_q;
  logic [FRAC_W-1:0] sum;

  assign in_cycle = (src == SRC_ALT) ? alt_pulse : xtal_pulse;
  assign sum      = {1'b0, rem_q} + presc;
  assign fire     = in_cycle & sum[FRAC_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rem_q <= '0;
    else if (in_cycle) rem_q <= sum[REM_W-1:0];
  end
endmodule

// File: rtl/ctb_counter.sv
module ctb_counter
  import ctb_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             step_two,
  output logic             tick,
  output logic [1:0]       inc,
  output logic [CNT_W-1:0] count
);
  logic [1:0] step;
  assign step = step_two ? INC_TWO : INC_ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick  <= 1'b0;
      inc   <= INC_NONE;
      count <= '0;
    end else begin
      tick <= fire;
      inc  <= fire ? step : INC_NONE;
      if (fire) count <= count + CNT_W'(step);
    end
  end
endmodule

// File: rtl/ctb_timebase.sv
module ctb_timebase
  import ctb_pkg::*;
#(
  parameter int FRAC_W = 32,
  parameter int CNT_W  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xtal_pulse_i,
  input  logic             alt_pulse_i,
  input  logic             cfg_wr_i,
  input  logic             cfg_sel_i,
  input  logic [31:0]      cfg_wdata_i,
  output logic             tick_o,
  output logic [1:0]       inc_o,
  output logic [CNT_W-1:0] count_o
);
  src_e              src;
  logic              step_two;
  logic [FRAC_W-1:0] presc;
  logic              fire;

  ctb_cfg_regs #(.FRAC_W(FRAC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr_i), .sel(cfg_sel_i),
    .wdata(cfg_wdata_i), .src(src), .step_two(step_two), .presc(presc)
  );

  ctb_frac_accum #(.FRAC_W(FRAC_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .xtal_pulse(xtal_pulse_i), .alt_pulse(alt_pulse_i),
    .src(src), .presc(presc), .fire(fire)
  );

  ctb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .fire(fire), .step_two(step_two),
    .tick(tick_o), .inc(inc_o), .count(count_o)
  );
endmodule

// File: rtl/ctb_timebase_chk.sv
module ctb_timebase_chk #(
  parameter int FRAC_W = 32,
  parameter int CNT_W  = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xtal_pulse_i,
  input logic             alt_pulse_i,
  input logic             src,
  input logic             step_two,
  input logic [FRAC_W-1:0] presc,
  input logic             tick_o,
  input logic [1:0]       inc_o,
  input logic [CNT_W-1:0] count_o
);
  localparam logic [FRAC_W-1:0] UNITY = FRAC_W'(1) << (FRAC_W - 1);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  // R1: a stopped prescaler never ticks
  assert_stopped_no_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    armed && presc == '0 |=> !tick_o);
  // R2: a tick needs a pulse on the selected input
  assert_tick_from_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && tick_o |-> $past(src ? alt_pulse_i : xtal_pulse_i));
  // R3: step output legal and matches the step bit
  assert_inc_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (tick_o ? (inc_o == (($past(step_two)) ? 2'd2 : 2'd1)) : (inc_o == 2'd0)));
  // R6: stored prescaler never exceeds unity
  assert_presc_clamped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    presc <= UNITY);
  // R4: unity prescaler ticks on every selected pulse
  assert_unity_every_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    armed && presc == UNITY && (src ? alt_pulse_i : xtal_pulse_i) |=> tick_o);
  // R7: counter advances by exactly the reported step
  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> count_o == $past(count_o) + CNT_W'(inc_o));
endmodule

bind ctb_timebase ctb_timebase_chk #(.FRAC_W(FRAC_W), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .xtal_pulse_i(xtal_pulse_i), .alt_pulse_i(alt_pulse_i),
  .src(src), .step_two(step_two), .presc(presc),
  .tick_o(tick_o), .inc_o(inc_o), .count_o(count_o)
);

// File: tb/test_ctb_timebase.sv
module test_ctb_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xp = 1'b0, ap = 1'b0;
  logic        wr = 1'b0, sel = 1'b0;
  logic [31:0] wdata = '0;
  logic        tick;
  logic [1:0]  inc;
  logic [63:0] count;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  ctb_timebase i_ctb_timebase (
    .clk(clk), .rst_n(rst_n), .xtal_pulse_i(xp), .alt_pulse_i(ap),
    .cfg_wr_i(wr), .cfg_sel_i(sel), .cfg_wdata_i(wdata),
    .tick_o(tick), .inc_o(inc), .count_o(count)
  );

  // behavioural reference model
  longint unsigned m_acc = 0, m_presc = 0, m_cnt = 0;
  bit m_src = 0, m_two = 0, m_tick = 0;
  int m_inc = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = 0; m_presc = 0; m_cnt = 0; m_src = 0; m_two = 0; m_tick = 0; m_inc = 0;
    end else begin
      longint unsigned p, s;
      bit pulse;
      p = (m_presc > 64'h8000_0000) ? 64'h8000_0000 : m_presc;
      pulse = m_src ? ap : xp;
      m_tick = 0; m_inc = 0;
      if (pulse) begin
        s = m_acc + p;
        if (s >= 64'h8000_0000) begin
          m_tick = 1; m_inc = m_two ? 2 : 1; m_cnt += m_inc;
        end
        m_acc = s % 64'h8000_0000;
      end
      if (wr) begin
        if (sel) m_presc = wdata;
        else begin m_src = wdata[8]; m_two = wdata[9]; end
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if (tick !== m_tick || inc !== 2'(m_inc) || count !== m_cnt) begin
      errors++;
      $display("FAIL %s: tick/inc/count actual %0b/%0d/%0d expected %0b/%0d/%0d",
               tag, tick, inc, count, m_tick, m_inc, m_cnt);
    end
  end

  task automatic cfg(input bit s, input logic [31:0] d);
    @(negedge clk); wr = 1; sel = s; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  // mode: 0 none, 1 every cycle, 2 sparse pseudo-random
  task automatic run(input int n, input int xm, input int am);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      xp = (xm == 1) || (xm == 2 && ($urandom % 3 == 0));
      ap = (am == 1) || (am == 2 && ($urandom % 2 == 0));
    end
    @(negedge clk); xp = 0; ap = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++; // R1 reset state
    if (count !== 0 || tick !== 0 || inc !== 0) begin
      errors++; $display("FAIL R1: reset actual %0d/%0b/%0d expected 0/0/0", count, tick, inc);
    end
    tag = "R1"; run(40, 1, 1);
    tag = "R4"; cfg(1, 32'h8000_0000); run(30, 1, 0); run(30, 2, 0);
    tag = "R2"; run(30, 0, 1);
    tag = "R7"; run(10, 0, 0);
    tag = "R5"; cfg(1, 32'h4000_0000); run(40, 1, 0);
    cfg(1, 32'h2000_0000); run(40, 2, 0);
    cfg(1, 32'h5555_5555); run(60, 1, 0); run(60, 2, 2);
    tag = "R3"; cfg(0, 32'h0000_0200); run(40, 1, 1);
    tag = "R2"; cfg(0, 32'h0000_0300); run(40, 2, 2); run(20, 1, 0);
    tag = "R8"; cfg(0, 32'h0000_0100); xp = 1; cfg(1, 32'h1234_5678); run(50, 2, 2);
    tag = "R3"; cfg(0, 32'h0); run(30, 1, 1);
    tag = "R6"; cfg(1, 32'hFFFF_FFFF); run(30, 1, 0); cfg(1, 32'h8000_0001); run(30, 2, 0);
    tag = "R1"; cfg(1, 32'h0); run(30, 1, 1);
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule